// File: doc/BRIEF.md
# Pseudo-SRAM Power Mode Sequencer

This block owns the power state of a pseudo-static RAM. After reset it holds the device in a power-up wait before any access is allowed. It then lets the access controller run while the device is active or in standby. It takes the device into deep power-down by driving the power-down pin low, and brings it back out again. The access controller looks at a single `ready` output: while `ready` is low, the sequencer owns the chip-enable line through an override pair, and no access may start.

Deep power-down keeps the pin low for at least a minimum interval. A wake request that arrives inside that interval is remembered and acted on once the interval ends. Leaving deep power-down takes a long settle wait after the pin rises. A parameter then picks one of two ways to finish the exit. One issues a number of dummy read strobes on chip enable. The other holds chip enable high for a longer time. Every entry into deep power-down raises a sticky flag that says the memory contents are lost. Only an explicit acknowledge clears it.

All waits are counted in microseconds. The microsecond tick is derived from a clock-frequency parameter and is restarted at each state entry, so every wait lasts a whole number of microseconds.

Top module: `psram_pwr_seq`

## Requirements
- R1: During reset and for INIT_US microseconds after reset is released, `ready` is 0, `pd_n` is 1, `ce_ovr_en` is 1 and `ce_ovr_n` is 1. `ready` rises exactly INIT_US*CLK_HZ/1e6 + 1 clock edges after release. `data_lost` resets to 0.
- R2: In the active state `ready` is 1, `pd_n` is 1 and `ce_ovr_en` is 0.
- R3: In the active state, `stby_hint` = 1 moves the block to standby on the next edge. There `ready` stays 1 and the override forces chip enable high (`ce_ovr_en` = 1, `ce_ovr_n` = 1). Dropping `stby_hint` returns to the active state on the next edge.
- R4: `sleep_req` while `ready` is 1 drives `pd_n` low and `ready` low on the next edge. It takes priority over `stby_hint`.
- R5: `pd_n` stays low for at least MIN_LOW_US microseconds after entry. A one-cycle `wake_req` seen inside that interval is latched. `pd_n` then rises MIN_LOW_US*CLK_HZ/1e6 + 1 edges after entry, with no further request.
- R6: `data_lost` becomes 1 on the edge where `pd_n` falls and stays 1 until `lost_ack` is seen. `lost_ack` clears it on the next edge in any state, except on an entry edge, where setting wins.
- R7: In deep power-down, `wake_req` raises `pd_n` on the next edge. `ready` then stays 0 for EXIT_US microseconds of settle time plus the exit finish.
- R8: With EXIT_DUMMY = 1, the settle wait is followed by DUMMY_READS strobes. Each strobe is `ce_ovr_n` low for RD_CYC cycles, then high for RD_CYC cycles. `ready` rises on the edge that ends the last high phase.
- R9: With EXIT_DUMMY = 0, the settle wait is followed by `ce_ovr_n` held high for HOLD_US microseconds. `ready` rises when that time has elapsed.
- R10: `wake_req` has no effect in the active or standby state. `sleep_req` has no effect while an exit is in progress.
- R11: While `pd_n` is 0, `ready` is 0 and chip enable is forced high (`ce_ovr_en` = 1, `ce_ovr_n` = 1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at CLK_HZ |
| rst_n | input | 1 | Asynchronous reset, active low |
| sleep_req | input | 1 | Request to enter deep power-down |
| wake_req | input | 1 | Request to leave deep power-down |
| stby_hint | input | 1 | Hint that the memory is idle and may be deselected |
| lost_ack | input | 1 | Clears the contents-lost flag |
| pd_n | output | 1 | Power-down pin level, low in deep power-down |
| ce_ovr_en | output | 1 | Sequencer owns chip enable when 1 |
| ce_ovr_n | output | 1 | Chip-enable level (active low) used while overriding |
| ready | output | 1 | Access controller may issue accesses |
| data_lost | output | 1 | Memory contents were invalidated by deep power-down |

## Verification
The assertions assume that all request inputs are synchronous to `clk` and are sampled only at rising edges. They also assume that `sleep_req` and `wake_req` are ordinary levels or one-cycle pulses, with no meaning attached to their overlap outside the states that use them. The stimulus changes every input on the falling edge and reads outputs on the next falling edge. Each request therefore lands on exactly one known rising edge, and every wait boundary can be checked on its exact cycle. Requests sent into the wrong state, such as a wake while active or a sleep during the exit, are sent on purpose. This shows that they leave the outputs untouched.

// File: rtl/psram_pwr_pkg.sv
package psram_pwr_pkg;

   typedef enum logic [2:0] {
      PS_INIT_WAIT  = 3'd0,
      PS_ACTIVE     = 3'd1,
      PS_STANDBY    = 3'd2,
      PS_DPD_ENTER  = 3'd3,
      PS_DPD        = 3'd4,
      PS_EXIT_WAIT  = 3'd5,
      PS_DUMMY_READ = 3'd6
   } pwr_state_e;

   function automatic int max3(input int a, input int b, input int c);
      int m;
      m = (a > b) ? a : b;
      return (m > c) ? m : c;
   endfunction

endpackage

// File: rtl/psram_us_timer.sv
module psram_us_timer #(
   parameter int CYC_PER_US = 50,
   parameter int CNT_W      = 8,
   parameter int RST_US     = 200
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_us,
   output logic             done
);

   localparam int PRE_W = $clog2(CYC_PER_US);

   generate
      if (CYC_PER_US < 2) begin : g_bad_div
         $error("psram_us_timer: CYC_PER_US must be at least 2");
      end
      if (RST_US >= (1 << CNT_W)) begin : g_bad_rst
         $error("psram_us_timer: RST_US does not fit CNT_W");
      end
   endgenerate

   logic [PRE_W-1:0] pre_q;
   logic [CNT_W-1:0] cnt_q;
   logic             tick;

   assign tick = (pre_q == PRE_W'(CYC_PER_US - 1));
   assign done = (cnt_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pre_q <= '0;
         cnt_q <= CNT_W'(RST_US);
      end else if (load) begin
         pre_q <= '0;
         cnt_q <= load_us;
      end else if (cnt_q != '0) begin
         pre_q <= tick ? '0 : pre_q + 1'b1;
         if (tick) cnt_q <= cnt_q - 1'b1;
      end
   end

   // expired timer stays expired until reloaded
   p_zero_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !load) |=> done);

endmodule

// File: rtl/psram_exit_finish.sv
module psram_exit_finish #(
   parameter bit EXIT_DUMMY  = 1'b1,
   parameter int RD_CYC      = 4,
   parameter int DUMMY_READS = 2,
   parameter int HOLD_CYC    = 15000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic done,
   output logic ce_n
);

   generate
      if (EXIT_DUMMY) begin : g_dummy
         localparam int SUB_W = $clog2(RD_CYC + 1);
         localparam int NRD_W = $clog2(DUMMY_READS + 1);

         logic             act_q;
         logic             high_q;
         logic [SUB_W-1:0] sub_q;
         logic [NRD_W-1:0] nrd_q;
         logic             sub_wrap;
         logic             last_rd;

         assign sub_wrap = (sub_q == SUB_W'(RD_CYC - 1));
         assign last_rd  = (nrd_q == NRD_W'(DUMMY_READS - 1));

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               act_q  <= 1'b0;
               high_q <= 1'b0;
               sub_q  <= '0;
               nrd_q  <= '0;
            end else if (start) begin
               act_q  <= 1'b1;
               high_q <= 1'b0;
               sub_q  <= '0;
               nrd_q  <= '0;
            end else if (act_q) begin
               if (sub_wrap) begin
                  sub_q  <= '0;
                  high_q <= ~high_q;
                  if (high_q) begin
                     if (last_rd) act_q <= 1'b0;
                     else         nrd_q <= nrd_q + 1'b1;
                  end
               end else begin
                  sub_q <= sub_q + 1'b1;
               end
            end
         end

         assign done = act_q && high_q && sub_wrap && last_rd;
         assign ce_n = !(act_q && !high_q);

         // strobe index never passes the configured read count
         p_read_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
            act_q |-> (nrd_q < NRD_W'(DUMMY_READS)));
      end else begin : g_hold
         localparam int HC_W = $clog2(HOLD_CYC + 1);

         logic            act_q;
         logic [HC_W-1:0] cnt_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               act_q <= 1'b0;
               cnt_q <= '0;
            end else if (start) begin
               act_q <= 1'b1;
               cnt_q <= HC_W'(HOLD_CYC - 1);
            end else if (act_q) begin
               if (cnt_q == '0) act_q <= 1'b0;
               else             cnt_q <= cnt_q - 1'b1;
            end
         end

         assign done = act_q && (cnt_q == '0);
         assign ce_n = 1'b1;

         // a running hold finishes only once its count is spent
         p_hold_len_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (act_q && cnt_q != '0 && !start) |=> act_q);
      end
   endgenerate

endmodule

// File: rtl/psram_pwr_fsm.sv
module psram_pwr_fsm
   import psram_pwr_pkg::*;
#(
   parameter int CNT_W       = 9,
   parameter int EXIT_US     = 200,
   parameter int MIN_LOW_US  = 1,
   parameter int MIN_LOW_CYC = 50
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sleep_req,
   input  logic             wake_req,
   input  logic             stby_hint,
   input  logic             lost_ack,
   input  logic             tmr_done,
   input  logic             fin_done,
   input  logic             fin_ce_n,
   output logic             tmr_load,
   output logic [CNT_W-1:0] tmr_us,
   output logic             fin_start,
   output logic             pd_n,
   output logic             ce_ovr_en,
   output logic             ce_ovr_n,
   output logic             ready,
   output logic             data_lost
);

   localparam int LOW_W = $clog2(MIN_LOW_CYC + 1);

   pwr_state_e state_q, state_nxt;
   logic       wake_pend_q;
   logic       lost_q;
   logic       enter;

   always_comb begin
      state_nxt = state_q;
      unique case (state_q)
         PS_INIT_WAIT:  if (tmr_done) state_nxt = PS_ACTIVE;
         PS_ACTIVE: begin
            if (sleep_req)      state_nxt = PS_DPD_ENTER;
            else if (stby_hint) state_nxt = PS_STANDBY;
         end
         PS_STANDBY: begin
            if (sleep_req)       state_nxt = PS_DPD_ENTER;
            else if (!stby_hint) state_nxt = PS_ACTIVE;
         end
         PS_DPD_ENTER: begin
            if (tmr_done) state_nxt = (wake_pend_q || wake_req) ? PS_EXIT_WAIT : PS_DPD;
         end
         PS_DPD:        if (wake_req) state_nxt = PS_EXIT_WAIT;
         PS_EXIT_WAIT:  if (tmr_done) state_nxt = PS_DUMMY_READ;
         PS_DUMMY_READ: if (fin_done) state_nxt = PS_ACTIVE;
         default:       state_nxt = PS_INIT_WAIT;
      endcase
   end

   assign enter     = (state_nxt != state_q);
   assign tmr_load  = enter;
   assign fin_start = enter && (state_nxt == PS_DUMMY_READ);

   always_comb begin
      unique case (state_nxt)
         PS_DPD_ENTER: tmr_us = CNT_W'(MIN_LOW_US);
         PS_EXIT_WAIT: tmr_us = CNT_W'(EXIT_US);
         default:      tmr_us = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= PS_INIT_WAIT;
         wake_pend_q <= 1'b0;
         lost_q      <= 1'b0;
      end else begin
         state_q     <= state_nxt;
         wake_pend_q <= (state_q == PS_DPD_ENTER) && (wake_pend_q || wake_req);
         if (enter && state_nxt == PS_DPD_ENTER) lost_q <= 1'b1;
         else if (lost_ack)                      lost_q <= 1'b0;
      end
   end

   assign pd_n      = !(state_q == PS_DPD_ENTER || state_q == PS_DPD);
   assign ready     = (state_q == PS_ACTIVE) || (state_q == PS_STANDBY);
   assign ce_ovr_en = (state_q != PS_ACTIVE);
   assign ce_ovr_n  = (state_q == PS_DUMMY_READ) ? fin_ce_n : 1'b1;
   assign data_lost = lost_q;

   // low-time monitor for the minimum pulse check
   logic [LOW_W-1:0] low_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                low_q <= '0;
      else if (pd_n)                             low_q <= '0;
      else if (low_q != LOW_W'(MIN_LOW_CYC))     low_q <= low_q + 1'b1;
   end

   p_min_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pd_n) |-> (low_q == LOW_W'(MIN_LOW_CYC)));

   p_lost_on_entry_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pd_n) |-> data_lost);

   p_lost_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (data_lost && !lost_ack) |=> data_lost);

   p_sleep_ignored_exit_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == PS_EXIT_WAIT && sleep_req) |=> pd_n);

   p_pd_deselect_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !pd_n |-> (ce_ovr_en && ce_ovr_n && !ready));

endmodule

// File: rtl/psram_pwr_seq.sv
module psram_pwr_seq
   import psram_pwr_pkg::*;
#(
   parameter int CLK_HZ      = 50_000_000,
   parameter int INIT_US     = 200,
   parameter int EXIT_US     = 200,
   parameter int MIN_LOW_US  = 1,
   parameter int HOLD_US     = 300,
   parameter bit EXIT_DUMMY  = 1'b1,
   parameter int DUMMY_READS = 2,
   parameter int RD_CYC      = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sleep_req,
   input  logic wake_req,
   input  logic stby_hint,
   input  logic lost_ack,
   output logic pd_n,
   output logic ce_ovr_en,
   output logic ce_ovr_n,
   output logic ready,
   output logic data_lost
);

   localparam int CYC_PER_US  = CLK_HZ / 1_000_000;
   localparam int MAX_US      = max3(INIT_US, EXIT_US, MIN_LOW_US);
   localparam int CNT_W       = $clog2(MAX_US + 1);
   localparam int HOLD_CYC    = HOLD_US * CYC_PER_US;
   localparam int MIN_LOW_CYC = MIN_LOW_US * CYC_PER_US;

   generate
      if ((CLK_HZ % 1_000_000) != 0 || CLK_HZ < 2_000_000) begin : g_bad_clk
         $error("psram_pwr_seq: CLK_HZ must be a whole number of MHz, at least 2");
      end
      if (MIN_LOW_US < 1 || INIT_US < 1 || EXIT_US < 1) begin : g_bad_wait
         $error("psram_pwr_seq: waits must be at least one microsecond");
      end
      if (EXIT_DUMMY && (DUMMY_READS < 1 || RD_CYC < 1)) begin : g_bad_rd
         $error("psram_pwr_seq: dummy read count and length must be positive");
      end
      if (!EXIT_DUMMY && HOLD_US < 1) begin : g_bad_hold
         $error("psram_pwr_seq: HOLD_US must be positive");
      end
   endgenerate

   logic             tmr_load;
   logic [CNT_W-1:0] tmr_us;
   logic             tmr_done;
   logic             fin_start;
   logic             fin_done;
   logic             fin_ce_n;

   psram_us_timer #(
      .CYC_PER_US (CYC_PER_US),
      .CNT_W      (CNT_W),
      .RST_US     (INIT_US)
   ) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (tmr_load),
      .load_us (tmr_us),
      .done    (tmr_done)
   );

   psram_exit_finish #(
      .EXIT_DUMMY  (EXIT_DUMMY),
      .RD_CYC      (RD_CYC),
      .DUMMY_READS (DUMMY_READS),
      .HOLD_CYC    (HOLD_CYC)
   ) u_finish (
      .clk   (clk),
      .rst_n (rst_n),
      .start (fin_start),
      .done  (fin_done),
      .ce_n  (fin_ce_n)
   );

   psram_pwr_fsm #(
      .CNT_W       (CNT_W),
      .EXIT_US     (EXIT_US),
      .MIN_LOW_US  (MIN_LOW_US),
      .MIN_LOW_CYC (MIN_LOW_CYC)
   ) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .sleep_req (sleep_req),
      .wake_req  (wake_req),
      .stby_hint (stby_hint),
      .lost_ack  (lost_ack),
      .tmr_done  (tmr_done),
      .fin_done  (fin_done),
      .fin_ce_n  (fin_ce_n),
      .tmr_load  (tmr_load),
      .tmr_us    (tmr_us),
      .fin_start (fin_start),
      .pd_n      (pd_n),
      .ce_ovr_en (ce_ovr_en),
      .ce_ovr_n  (ce_ovr_n),
      .ready     (ready),
      .data_lost (data_lost)
   );

   // chip enable is never released while access is blocked
   p_ready_gates_ce_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !ready |-> ce_ovr_en);

endmodule

// File: tb/tb_psram_pwr_seq.sv
module tb_psram_pwr_seq;

   localparam int CPU   = 50;
   localparam int INIT  = 200;
   localparam int EXITW = 200;
   localparam int HOLD  = 300;
   localparam int RD    = 4;
   localparam int NRD   = 2;
   localparam int LEN   = 2 * NRD * RD;
   localparam int HLEN  = HOLD * CPU;
   localparam int KF    = EXITW * CPU + 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sleep_req = 1'b0, wake_req = 1'b0, stby_hint = 1'b0, lost_ack = 1'b0;
   logic pd_n, ce_ovr_en, ce_ovr_n, ready, data_lost;
   logic pd_n_h, ce_ovr_en_h, ce_ovr_n_h, ready_h, data_lost_h;

   int total = 0;
   int fails = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;

   psram_pwr_seq #(.EXIT_DUMMY(1'b1)) dut (
      .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .wake_req(wake_req),
      .stby_hint(stby_hint), .lost_ack(lost_ack), .pd_n(pd_n),
      .ce_ovr_en(ce_ovr_en), .ce_ovr_n(ce_ovr_n), .ready(ready), .data_lost(data_lost));

   psram_pwr_seq #(.EXIT_DUMMY(1'b0)) dut_hold (
      .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .wake_req(wake_req),
      .stby_hint(stby_hint), .lost_ack(lost_ack), .pd_n(pd_n_h),
      .ce_ovr_en(ce_ovr_en_h), .ce_ovr_n(ce_ovr_n_h), .ready(ready_h), .data_lost(data_lost_h));

   // {sleep, wake, stby, ack} -> {ready, pd_n, ce_ovr_en, ce_ovr_n, data_lost}
   localparam logic [8:0] VEC [7] = '{
      9'b0000_11010,   // R2 plain active
      9'b0100_11010,   // R10 wake while active
      9'b0010_11110,   // R3 enter standby
      9'b0010_11110,   // R3 stay in standby
      9'b0000_11010,   // R3 back to active
      9'b0001_11010,   // R6 ack with flag clear
      9'b1010_00111    // R4 sleep beats standby, R6 flag set
   };

   function automatic string vec_req(input int i);
      case (i)
         0: return "R2";
         1: return "R10";
         2, 3, 4: return "R3";
         5: return "R6";
         default: return "R4";
      endcase
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic step(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         total++;
         fails++;
         $display("FAIL R1 watchdog actual=running expected=done");
         summary();
      end
   end

   initial begin
      // R1 reset state
      step(3);
      chk("R1", {ready, pd_n, ce_ovr_en, ce_ovr_n, data_lost}, 5'b01110);
      rst_n = 1'b1;
      step(INIT * CPU);
      chk("R1", {ready, ready_h, pd_n}, 3'b001);
      step(1);
      chk("R1", {ready, ready_h, ce_ovr_en}, 3'b110);

      // table walk: active, standby, entry
      for (int i = 0; i < 7; i++) begin
         {sleep_req, wake_req, stby_hint, lost_ack} = VEC[i][8:5];
         step(1);
         chk(vec_req(i), {ready, pd_n, ce_ovr_en, ce_ovr_n, data_lost}, {27'd0, VEC[i][4:0]});
      end
      {sleep_req, wake_req, stby_hint, lost_ack} = 4'b0000;

      // R5 minimum low time, no wake: stays down
      step(CPU);
      chk("R5", {pd_n}, 1'b0);
      step(1);
      chk("R11", {pd_n, ready, ce_ovr_en, ce_ovr_n}, 4'b0011);
      step(10);
      chk("R11", {pd_n, ready}, 2'b00);

      // R6 ack clears the flag while powered down
      lost_ack = 1'b1;
      step(1);
      lost_ack = 1'b0;
      chk("R6", {data_lost, data_lost_h}, 2'b00);

      // R7 wake from deep power-down
      step(5);
      wake_req = 1'b1;
      step(1);
      wake_req = 1'b0;
      chk("R7", {pd_n, ready}, 2'b10);
      sleep_req = 1'b1;
      step(1);
      sleep_req = 1'b0;
      chk("R10", {pd_n, ready}, 2'b10);
      step(KF - 1 - 2);
      chk("R7", {ready, ce_ovr_n, ready_h}, 3'b010);

      // R8 dummy strobes / R9 hold
      step(1);
      chk("R8", {ce_ovr_n}, 1'b0);
      chk("R9", {ce_ovr_n_h, ce_ovr_en_h}, 2'b11);
      step(RD - 1);
      chk("R8", {ce_ovr_n}, 1'b0);
      step(1);
      chk("R8", {ce_ovr_n}, 1'b1);
      step(RD);
      chk("R8", {ce_ovr_n, ready}, 2'b00);
      step(LEN - 2 * RD - 1);
      chk("R8", {ready, ce_ovr_n}, 2'b01);
      step(1);
      chk("R8", {ready, ce_ovr_en}, 2'b10);
      step(HLEN - LEN - 1);
      chk("R9", {ready_h, ce_ovr_n_h}, 2'b01);
      step(1);
      chk("R9", {ready_h, ce_ovr_en_h}, 2'b10);

      // R5 short wake inside the minimum low window is latched
      sleep_req = 1'b1;
      step(1);
      sleep_req = 1'b0;
      chk("R4", {pd_n, ready, data_lost}, 3'b001);
      wake_req = 1'b1;
      step(1);
      wake_req = 1'b0;
      step(CPU - 1);
      chk("R5", {pd_n}, 1'b0);
      step(1);
      chk("R5", {pd_n, ready, data_lost}, 3'b101);

      // R6 ack on the way out clears
      lost_ack = 1'b1;
      step(1);
      lost_ack = 1'b0;
      chk("R6", {data_lost}, 1'b0);

      begin
         int w = 0;
         while (!(ready && ready_h) && w < 40000) begin
            step(1);
            w++;
         end
         chk("R7", {ready, ready_h, pd_n}, 3'b111);
      end

      // R6 ack coinciding with entry: set wins
      sleep_req = 1'b1;
      lost_ack  = 1'b1;
      step(1);
      sleep_req = 1'b0;
      lost_ack  = 1'b0;
      chk("R6", {data_lost, pd_n}, 2'b10);

      // R1 reset mid power-down
      step(3);
      rst_n = 1'b0;
      step(2);
      chk("R1", {ready, pd_n, ce_ovr_en, ce_ovr_n, data_lost}, 5'b01110);

      finished = 1'b1;
      summary();
   end

endmodule